// File: doc/BRIEF.md
# Output Impedance Update Scheduler

This block decides in which clock cycle a freshly measured output-driver calibration code may be copied into the setting that the drivers actually use. Changing that setting while the data pins are being driven would disturb the data, so the block only lets a new code through in a cycle where the outputs are quiet. A cycle is quiet when no read data is being driven, for example a deselected cycle or one with output enable high. Updates are also rate-limited. An interval counter runs on every clock edge, whatever kind of cycle it is, and an update becomes eligible only once that counter has reached a minimum spacing.

The counter stops at that minimum and stays there. An eligible update therefore waits for as long as the outputs stay busy, and fires at the first quiet edge that follows. Each update copies the input code into the applied code, raises a one-cycle strobe and restarts the interval.

A second counter accumulates quiet cycles from reset. It raises a sticky status flag once enough of them have passed for the driver strength to be trusted. The code itself is opaque to the block.

Top module: `zq_upd_sched`

## Requirements
- R1: While reset is held and after it is released, `drv_code` equals the mid-scale value 2^(CODE_W-1) (32 for the default width of 6), and `upd_stb` and `imp_ready` are 0.
- R2: The interval counter advances by one on every clock edge out of reset, whether `out_busy` is high or low. It stops at MIN_GAP.
- R3: An update fires at a clock edge only when the interval counter holds MIN_GAP and `out_busy` is low. With `out_busy` held low from reset, the first strobe is visible after the (MIN_GAP+1)-th edge, which is the 33rd edge with the default values.
- R4: At an update edge, `drv_code` takes the `cal_code` value present at that edge, and `upd_stb` is 1 for exactly the one following cycle. At all other edges `drv_code` holds its value.
- R5: An update restarts the interval counter at 0. Two strobes are therefore at least MIN_GAP+1 edges apart, and exactly that far apart when `out_busy` stays low.
- R6: No update fires at an edge where `out_busy` is high, so `drv_code` does not change there.
- R7: After a busy stream longer than MIN_GAP cycles, the pending update fires at the first edge where `out_busy` is low.
- R8: `imp_ready` rises after the SETTLE_CYCLES-th edge with `out_busy` low, counted cumulatively from reset. Busy edges are neither counted nor do they clear the count.
- R9: Once `imp_ready` is set, it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| out_busy | input | 1 | High in a cycle that drives read data with output enable active |
| cal_code | input | CODE_W | Calibration code offered by the measurement logic |
| drv_code | output | CODE_W | Code currently applied to the output drivers |
| upd_stb | output | 1 | One-cycle pulse marking a cycle in which `drv_code` has just changed |
| imp_ready | output | 1 | Sticky flag: enough quiet cycles have passed since reset |

## Verification
The hardest situation to reach is an update that is already eligible but held back. The interval counter has to sit at its limit while the outputs stay busy, and the release then has to come on exactly the first quiet edge. The stimulus holds `out_busy` high for far longer than MIN_GAP from reset and checks at every edge that no strobe appears. It then changes `cal_code` and drops `out_busy` for one edge, which shows that the deferred update captures the newest code. The settle count is reached with busy and quiet cycles interleaved, so that the flag can only rise on the exact cumulative quiet count.

// File: rtl/zq_sched_pkg.sv
// Package: zq_sched_pkg
// Shared default values for the impedance update scheduler. Every module
// takes these as parameter defaults, so the whole block can be re-sized
// from one place.
package zq_sched_pkg;
    localparam int unsigned ZQ_CODE_W_DEF  = 6;
    localparam int unsigned ZQ_MIN_GAP_DEF = 32;
    localparam int unsigned ZQ_SETTLE_DEF  = 1024;
endpackage

// File: rtl/zq_gap_counter.sv
// Module: zq_gap_counter
// Counts clock edges since the last update and stops at MIN_GAP. While it
// holds MIN_GAP it reports that an update is eligible. It assumes that the
// fire input can only be high while it reports eligibility.
module zq_gap_counter #(
    parameter int unsigned MIN_GAP = zq_sched_pkg::ZQ_MIN_GAP_DEF,
    localparam int unsigned GW     = $clog2(MIN_GAP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire_i,
    output logic [GW-1:0] gap_cnt_o,
    output logic          ripe_o
);
    localparam logic [GW-1:0] GAP_LIM = GW'(MIN_GAP);

    logic [GW-1:0] gap_cnt;

    // Advance on every edge, stop at the limit, restart when an update fires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (fire_i) begin
            gap_cnt <= '0;
        end else if (gap_cnt != GAP_LIM) begin
            gap_cnt <= gap_cnt + GW'(1);
        end
    end

    assign gap_cnt_o = gap_cnt;
    assign ripe_o    = (gap_cnt == GAP_LIM);

    // R2: below the limit the counter steps by one at every edge, whatever the cycle type.
    p_gap_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && gap_cnt != GAP_LIM) |=> (gap_cnt == $past(gap_cnt) + GW'(1)))
        else $error("gap counter failed to advance");

    // R2: the counter never runs past its limit.
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gap_cnt <= GAP_LIM)
        else $error("gap counter overflow");

    // R3: an update may only be requested while eligible.
    p_fire_ripe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |-> ripe_o)
        else $error("fire outside eligibility");
endmodule

// File: rtl/zq_settle_tracker.sv
// Module: zq_settle_tracker
// Accumulates quiet cycles from reset and raises a sticky ready flag once
// SETTLE_CYCLES of them have passed. Busy cycles leave the count untouched.
module zq_settle_tracker #(
    parameter int unsigned SETTLE_CYCLES = zq_sched_pkg::ZQ_SETTLE_DEF,
    localparam int unsigned SW           = $clog2(SETTLE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic quiet_i,
    output logic ready_o
);
    localparam logic [SW-1:0] SETTLE_LIM = SW'(SETTLE_CYCLES);

    logic [SW-1:0] quiet_cnt;

    // Count quiet edges until the limit is reached, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_cnt <= '0;
        end else if (quiet_i && quiet_cnt != SETTLE_LIM) begin
            quiet_cnt <= quiet_cnt + SW'(1);
        end
    end

    assign ready_o = (quiet_cnt == SETTLE_LIM);

    // R8: a busy edge neither adds to the count nor clears it.
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !quiet_i) |=> $stable(quiet_cnt))
        else $error("settle count moved on a busy cycle");

    // R9: the ready flag is sticky.
    p_ready_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && ready_o) |=> ready_o)
        else $error("ready flag dropped");
endmodule

// File: rtl/zq_code_holder.sv
// Module: zq_code_holder
// Holds the code applied to the drivers. On a load it captures the
// incoming code and raises a one-cycle strobe together with the new value.
// Reset restores the default code.
module zq_code_holder #(
    parameter int unsigned      CODE_W   = zq_sched_pkg::ZQ_CODE_W_DEF,
    parameter logic [CODE_W-1:0] DEF_CODE = CODE_W'(1) << (CODE_W - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] code_o,
    output logic              strobe_o
);
    logic [CODE_W-1:0] code_q;
    logic              stb_q;

    // Capture the new code on a load, otherwise keep the applied one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= DEF_CODE;
        end else if (load_i) begin
            code_q <= code_i;
        end
    end

    // The strobe follows the load by one edge, aligned with the new code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= 1'b0;
        end else begin
            stb_q <= load_i;
        end
    end

    assign code_o   = code_q;
    assign strobe_o = stb_q;

    // R4: the applied code is stable in every cycle without a strobe.
    p_code_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && !stb_q) |-> $stable(code_q))
        else $error("applied code changed without strobe");
endmodule

// File: rtl/zq_upd_sched.sv
// Module: zq_upd_sched (top)
// Schedules the transfer of a calibration code to the output drivers. An
// update fires when the interval counter has reached MIN_GAP and the
// current cycle does not drive the outputs. A separate tracker reports
// readiness after SETTLE_CYCLES quiet cycles. It assumes that out_busy is
// synchronous to clk.
module zq_upd_sched #(
    parameter int unsigned CODE_W        = zq_sched_pkg::ZQ_CODE_W_DEF,
    parameter int unsigned MIN_GAP       = zq_sched_pkg::ZQ_MIN_GAP_DEF,
    parameter int unsigned SETTLE_CYCLES = zq_sched_pkg::ZQ_SETTLE_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              out_busy,
    input  logic [CODE_W-1:0] cal_code,
    output logic [CODE_W-1:0] drv_code,
    output logic              upd_stb,
    output logic              imp_ready
);
    localparam int unsigned       GW       = $clog2(MIN_GAP + 1);
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    logic          gap_ripe;
    logic [GW-1:0] gap_cnt;
    logic          fire;

    // Eligible and quiet: this edge applies the new code.
    assign fire = gap_ripe && !out_busy;

    zq_gap_counter #(.MIN_GAP(MIN_GAP)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (fire),
        .gap_cnt_o(gap_cnt),
        .ripe_o   (gap_ripe)
    );

    zq_settle_tracker #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .quiet_i(!out_busy),
        .ready_o(imp_ready)
    );

    zq_code_holder #(.CODE_W(CODE_W), .DEF_CODE(MID_CODE)) u_code (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (fire),
        .code_i  (cal_code),
        .code_o  (drv_code),
        .strobe_o(upd_stb)
    );

    // R6: a busy edge never produces a strobe.
    p_no_busy_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && out_busy) |=> !upd_stb)
        else $error("update during busy cycle");

    // R4: the strobe lasts a single cycle.
    p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |=> !upd_stb)
        else $error("strobe longer than one cycle");

    // R5: a strobe coincides with a restarted interval.
    p_gap_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |-> (gap_cnt == '0))
        else $error("interval not restarted by update");
endmodule

// File: tb/zq_upd_sched_tb.sv
module zq_upd_sched_tb_top;
    localparam int unsigned CW  = 6;
    localparam int unsigned GAP = 32;
    localparam int unsigned SET = 1024;
    localparam logic [CW-1:0] MID = 6'd32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          out_busy;
    logic [CW-1:0] cal_code;
    logic [CW-1:0] drv_code;
    logic          upd_stb;
    logic          imp_ready;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    zq_upd_sched #(.CODE_W(CW), .MIN_GAP(GAP), .SETTLE_CYCLES(SET)) dut_i (
        .clk(clk), .rst_n(rst_n), .out_busy(out_busy), .cal_code(cal_code),
        .drv_code(drv_code), .upd_stb(upd_stb), .imp_ready(imp_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance n rising edges and stop on the following falling edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        out_busy = 1'b0;
        cal_code = 6'd5;
        step(3);
        rst_n = 1'b1;
    endtask

    // R1: outputs at reset.
    task automatic t_reset();
        do_reset();
        chk("R1 code", 32'(drv_code), 32'(MID));
        chk("R1 strobe", 32'(upd_stb), 0);
        chk("R1 ready", 32'(imp_ready), 0);
    endtask

    // R2, R3, R4, R5: continuous quiet stream.
    task automatic t_quiet();
        do_reset();
        cal_code = 6'd11;
        step(GAP);
        chk("R3 no early strobe", 32'(upd_stb), 0);
        chk("R2 code unchanged early", 32'(drv_code), 32'(MID));
        step(1);
        chk("R3 first strobe", 32'(upd_stb), 1);
        chk("R4 code loaded", 32'(drv_code), 11);
        cal_code = 6'd40;
        step(1);
        chk("R4 strobe one cycle", 32'(upd_stb), 0);
        chk("R4 code held", 32'(drv_code), 11);
        step(GAP - 1);
        chk("R5 no strobe before gap", 32'(upd_stb), 0);
        step(1);
        chk("R5 second strobe", 32'(upd_stb), 1);
        chk("R5 second code", 32'(drv_code), 40);
    endtask

    // R6, R7, R2: a long busy stream defers the update.
    task automatic t_defer();
        int stb_seen = 0;
        do_reset();
        out_busy = 1'b1;
        for (int i = 0; i < 100; i++) begin
            step(1);
            if (upd_stb) stb_seen++;
        end
        chk("R6 no strobe while busy", 32'(stb_seen), 0);
        chk("R6 code held while busy", 32'(drv_code), 32'(MID));
        cal_code = 6'd7;
        out_busy = 1'b0;
        step(1);
        chk("R7 strobe at first quiet edge", 32'(upd_stb), 1);
        chk("R7 newest code captured", 32'(drv_code), 7);
        out_busy = 1'b1;
        step(40);
        chk("R6 code held after defer", 32'(drv_code), 7);
    endtask

    // R8, R9, R1: cumulative settle count and reset clearing it.
    task automatic t_settle();
        do_reset();
        for (int i = 0; i < 2 * SET - 2; i++) begin
            out_busy = (i % 2) == 1;
            step(1);
        end
        chk("R8 not ready at count-1", 32'(imp_ready), 0);
        out_busy = 1'b0;
        step(1);
        chk("R8 ready at count", 32'(imp_ready), 1);
        out_busy = 1'b1;
        step(10);
        chk("R9 ready sticky", 32'(imp_ready), 1);
        rst_n = 1'b0;
        step(1);
        chk("R1 ready cleared", 32'(imp_ready), 0);
        chk("R1 code restored", 32'(drv_code), 32'(MID));
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_quiet();
        t_defer();
        t_settle();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule